// File: doc/BRIEF.md
# Power-Fail Guarded RAM Bank Chip-Enable Gate

This block sits between a host bus and two external static RAM banks. A host chip enable and a one-bit bank select route the access to exactly one of two active-low RAM chip enables. A second, external chip enable diverts the access away from the RAM banks to an internal register space; that register select is produced here, and so is a register write enable.

A digital power-good input, standing in for a supply monitor, runs through a two-stage synchronizer into a three-state machine. The states are POWER_FAIL, RECOVERY and POWER_OK. Reset enters POWER_FAIL. The transitions are:

- fail_to_recover: POWER_FAIL goes to RECOVERY when the synchronized power-good is high.
- recover_abort: RECOVERY goes back to POWER_FAIL when it is low.
- recover_done: RECOVERY goes to POWER_OK after `RECOVER_CYCLES` cycles.
- ok_to_fail: POWER_OK goes to POWER_FAIL when it is low.

Both RAM chip enables and the register write enable are allowed only in POWER_OK while the synchronized power-good is high. A supply drop therefore cuts off an access that is already in progress, without waiting for the host to end it.

Top module: `pfg_bank_gate`

## Requirements
- R1: While `rst_n` is low, and after its release until recovery completes, both `ram_ce0_n` and `ram_ce1_n` are high and `reg_we` is low, whatever the host inputs are.
- R2: With access enabled, `host_ce_n` low and `ext_ce_n` high, `bank_sel`=0 drives `ram_ce0_n` low and `ram_ce1_n` high, and `bank_sel`=1 does the reverse. The two outputs are never low together.
- R3: With `host_ce_n` high, both RAM chip enables are high.
- R4: With `ext_ce_n` low, both RAM chip enables are high. `reg_cs` is high exactly when `host_ce_n` and `ext_ce_n` are both low, independent of power state.
- R5: `reg_we` is high exactly when `reg_cs` is high, `wr_n` is low and access is enabled.
- R6: After `pwr_good` is first sampled low at a rising edge, the RAM chip enables go high right after the next rising edge, even though `host_ce_n` stays low.
- R7: From POWER_FAIL, with `pwr_good` held high, access becomes enabled right after the (`RECOVER_CYCLES`+3)-th rising edge, counting the first edge that samples it high as the first. This is two synchronizer edges, one fail_to_recover edge and `RECOVER_CYCLES` edges in RECOVERY.
- R8: A low sample of `pwr_good` during RECOVERY (recover_abort) discards the progress made, and the full latency of R7 restarts from the next high sample.
- R9: POWER_FAIL never passes straight to POWER_OK. Access stays disabled for as long as `pwr_good` stays low.
- R10: A low pulse on `pwr_good` that lasts a single sample while in POWER_OK (ok_to_fail) disables access. Access then returns only after the full latency of R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ce_n | input | 1 | Host chip enable, active low |
| ext_ce_n | input | 1 | External chip enable, active low; selects internal registers |
| bank_sel | input | 1 | RAM bank select: 0 selects bank 0, 1 selects bank 1 |
| wr_n | input | 1 | Host write strobe, active low |
| pwr_good | input | 1 | Asynchronous power-good indication, high when the supply is in tolerance |
| ram_ce0_n | output | 1 | Chip enable of RAM bank 0, active low |
| ram_ce1_n | output | 1 | Chip enable of RAM bank 1, active low |
| reg_cs | output | 1 | Internal register select, active high |
| reg_we | output | 1 | Internal register write enable, active high |

## Verification
Two functions can fall in the same cycle. A host access that is still being decoded can meet a falling synchronized power-good, and a recovery that is about to finish can meet a fresh low sample. The bench holds `host_ce_n` low with a bank selected while it drops `pwr_good`. It also pulses `pwr_good` low both inside RECOVERY and for one sample in POWER_OK. A behavioural model counts consecutive high synchronized samples and is compared with every output at each falling edge. Edge-counted latency checks then confirm that the cut-off takes two edges and that re-enable takes `RECOVER_CYCLES`+3 edges.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    localparam int NUM_BANKS = 2;

    typedef enum logic [1:0] {
        ST_POWER_FAIL = 2'd0,
        ST_RECOVERY   = 2'd1,
        ST_POWER_OK   = 2'd2
    } pwr_state_e;

endpackage

// File: rtl/pfg_pg_sync.sv
module pfg_pg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pg_async,
    output logic pg_sync
);

    logic [STAGES-1:0] stage_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= 1'b0;
                else        stage_q[0] <= pg_async;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= 1'b0;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign pg_sync = stage_q[STAGES-1];

endmodule

// File: rtl/pfg_fsm.sv
module pfg_fsm
    import pfg_pkg::*;
#(
    parameter int RECOVER_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pg_sync,
    output pwr_state_e state,
    output logic       access_en
);

    localparam int CW = (RECOVER_CYCLES < 2) ? 1 : $clog2(RECOVER_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(RECOVER_CYCLES - 1);

    pwr_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_POWER_FAIL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and recovery count
    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        unique case (state_q)
            ST_POWER_FAIL: begin
                if (pg_sync) state_d = ST_RECOVERY;   // fail_to_recover
            end
            ST_RECOVERY: begin
                if (!pg_sync) begin
                    state_d = ST_POWER_FAIL;          // recover_abort
                end else if (cnt_q == LAST) begin
                    state_d = ST_POWER_OK;            // recover_done
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_POWER_OK: begin
                if (!pg_sync) state_d = ST_POWER_FAIL; // ok_to_fail
            end
            default: state_d = ST_POWER_FAIL;
        endcase
    end

    // Output process: gate also on the live synced level so a drop cuts access at once
    always_comb begin
        state     = state_q;
        access_en = 1'b0;
        unique case (state_q)
            ST_POWER_OK:   access_en = pg_sync;
            ST_RECOVERY:   access_en = 1'b0;
            ST_POWER_FAIL: access_en = 1'b0;
            default:       access_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/pfg_decode.sv
module pfg_decode
    import pfg_pkg::*;
(
    input  logic                 access_en,
    input  logic                 host_ce_n,
    input  logic                 ext_ce_n,
    input  logic                 bank_sel,
    input  logic                 wr_n,
    output logic [NUM_BANKS-1:0] ram_ce_n,
    output logic                 reg_cs,
    output logic                 reg_we
);

    logic ram_path;

    assign ram_path = access_en && !host_ce_n && ext_ce_n;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign ram_ce_n[g] = !(ram_path && (bank_sel == 1'(g)));
    end

    assign reg_cs = !host_ce_n && !ext_ce_n;
    assign reg_we = reg_cs && !wr_n && access_en;

endmodule

// File: rtl/pfg_bank_gate.sv
module pfg_bank_gate
    import pfg_pkg::*;
#(
    parameter int RECOVER_CYCLES = 16,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_ce_n,
    input  logic ext_ce_n,
    input  logic bank_sel,
    input  logic wr_n,
    input  logic pwr_good,
    output logic ram_ce0_n,
    output logic ram_ce1_n,
    output logic reg_cs,
    output logic reg_we
);

    logic                 pg_sync;
    logic                 access_en;
    pwr_state_e           fsm_state;
    logic [NUM_BANKS-1:0] ce_n;

    pfg_pg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pg_async (pwr_good),
        .pg_sync  (pg_sync)
    );

    pfg_fsm #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pg_sync   (pg_sync),
        .state     (fsm_state),
        .access_en (access_en)
    );

    pfg_decode u_dec (
        .access_en (access_en),
        .host_ce_n (host_ce_n),
        .ext_ce_n  (ext_ce_n),
        .bank_sel  (bank_sel),
        .wr_n      (wr_n),
        .ram_ce_n  (ce_n),
        .reg_cs    (reg_cs),
        .reg_we    (reg_we)
    );

    assign ram_ce0_n = ce_n[0];
    assign ram_ce1_n = ce_n[1];

endmodule

// File: rtl/pfg_bank_gate_chk.sv
module pfg_bank_gate_chk
    import pfg_pkg::*;
#(
    parameter int RECOVER_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       host_ce_n,
    input logic       ext_ce_n,
    input logic       wr_n,
    input logic       ram_ce0_n,
    input logic       ram_ce1_n,
    input logic       reg_cs,
    input logic       reg_we,
    input logic       pg_sync,
    input pwr_state_e state
);

    localparam int LW = $clog2(RECOVER_CYCLES + 2);

    logic [LW-1:0] rec_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     rec_len <= '0;
        else if (state == ST_RECOVERY)  rec_len <= rec_len + 1'b1;
        else                            rec_len <= '0;
    end

    // R2: never both banks selected
    a_r2_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!ram_ce0_n, !ram_ce1_n}) <= 1);

    // R3: no RAM access without host enable
    a_r3_host_idle: assert property (@(posedge clk) disable iff (!rst_n)
        host_ce_n |-> (ram_ce0_n && ram_ce1_n));

    // R4: register space and RAM are exclusive
    a_r4_reg_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_ce_n || reg_cs) |-> (ram_ce0_n && ram_ce1_n));

    // R5: register writes only with power up and a write strobe
    a_r5_wr_block: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (state == ST_POWER_OK && pg_sync && !wr_n && !host_ce_n));

    // R6: RAM cut as soon as synced power-good is low
    a_r6_cut: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_sync |-> (ram_ce0_n && ram_ce1_n && !reg_we));

    // R1: no access outside POWER_OK
    a_r1_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_POWER_OK) |-> (ram_ce0_n && ram_ce1_n && !reg_we));

    // R10: ok_to_fail on a low synced sample
    a_r10_ok_to_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POWER_OK && !pg_sync) |=> (state == ST_POWER_FAIL));

    // R9: POWER_OK only entered from RECOVERY
    a_r9_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POWER_OK && $past(state) != ST_POWER_OK) |-> ($past(state) == ST_RECOVERY));

    // R7: RECOVERY lasts exactly RECOVER_CYCLES cycles
    a_r7_recover_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POWER_OK && $past(state) == ST_RECOVERY) |-> ($past(rec_len) == LW'(RECOVER_CYCLES - 1)));

    // R8: recover_abort on a low synced sample
    a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOVERY && !pg_sync) |=> (state == ST_POWER_FAIL));

endmodule

bind pfg_bank_gate pfg_bank_gate_chk #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_ce_n (host_ce_n),
    .ext_ce_n  (ext_ce_n),
    .wr_n      (wr_n),
    .ram_ce0_n (ram_ce0_n),
    .ram_ce1_n (ram_ce1_n),
    .reg_cs    (reg_cs),
    .reg_we    (reg_we),
    .pg_sync   (pg_sync),
    .state     (fsm_state)
);

// File: tb/sim_pfg_bank_gate.sv
`timescale 1ns/1ps
module sim_pfg_bank_gate;

    localparam int RC = 5;

    logic clk = 1'b0;
    logic rst_n, host_ce_n, ext_ce_n, bank_sel, wr_n, pwr_good;
    logic ram_ce0_n, ram_ce1_n, reg_cs, reg_we;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    pfg_bank_gate #(.RECOVER_CYCLES(RC)) u0 (
        .clk(clk), .rst_n(rst_n), .host_ce_n(host_ce_n), .ext_ce_n(ext_ce_n),
        .bank_sel(bank_sel), .wr_n(wr_n), .pwr_good(pwr_good),
        .ram_ce0_n(ram_ce0_n), .ram_ce1_n(ram_ce1_n), .reg_cs(reg_cs), .reg_we(reg_we)
    );

    // Behavioural reference: synchronizer as two bits, and a run length of high synced samples
    bit m_s1, m_s2;
    int run;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 1'b0; m_s2 = 1'b0; run = 0;
        end else begin
            m_s2 = m_s1;
            m_s1 = pwr_good;
            if (!m_s2)          run = 0;
            else if (run < 1000) run = run + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit en, e0, e1, ecs, ewe;
        string rq;
        en  = (run >= RC + 2);
        e0  = !(en && !host_ce_n && ext_ce_n && !bank_sel);
        e1  = !(en && !host_ce_n && ext_ce_n &&  bank_sel);
        ecs = !host_ce_n && !ext_ce_n;
        ewe = ecs && !wr_n && en;
        if (!en)            rq = cur_req;
        else if (!ext_ce_n) rq = "R4";
        else if (host_ce_n) rq = "R3";
        else                rq = "R2";
        chk(ram_ce0_n == e0, rq, "ram_ce0_n", ram_ce0_n, e0);
        chk(ram_ce1_n == e1, rq, "ram_ce1_n", ram_ce1_n, e1);
        chk(reg_cs == ecs, "R4", "reg_cs", reg_cs, ecs);
        chk(reg_we == ewe, en ? "R5" : cur_req, "reg_we", reg_we, ewe);
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    // Count edges until the bank-0 enable reaches the wanted level
    task automatic wait_ce0(input bit want, output int k);
        k = 0;
        for (int i = 1; i <= 60; i++) begin
            step();
            k = i;
            if (ram_ce0_n == want) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int k;
        rst_n = 1'b0; host_ce_n = 1'b0; ext_ce_n = 1'b1; bank_sel = 1'b0; wr_n = 1'b0; pwr_good = 1'b1;

        // R1: reset holds everything off even with power good
        cur_req = "R1";
        repeat (4) step();
        chk(ram_ce0_n && ram_ce1_n, "R1", "ce during reset", {ram_ce0_n, ram_ce1_n}, 3);
        rst_n = 1'b1;

        // R7: release latency from reset (power good already present)
        cur_req = "R7";
        wait_ce0(1'b0, k);
        chk(k == RC + 3, "R7", "enable latency after reset", k, RC + 3);

        // R6: drop power mid-access on bank 0
        cur_req = "R6";
        pwr_good = 1'b0;
        wait_ce0(1'b1, k);
        chk(k == 2, "R6", "cut-off latency", k, 2);

        // R9: stays off through a long fail
        cur_req = "R9";
        repeat (30) step();
        chk(ram_ce0_n && ram_ce1_n, "R9", "ce in long fail", {ram_ce0_n, ram_ce1_n}, 3);

        // R7: restore power and measure
        cur_req = "R7";
        pwr_good = 1'b1;
        wait_ce0(1'b0, k);
        chk(k == RC + 3, "R7", "enable latency", k, RC + 3);

        // R2/R3/R4/R5: mixed traffic with power up
        cur_req = "R2";
        for (int i = 0; i < 300; i++) begin
            step();
            host_ce_n = 1'($urandom);
            ext_ce_n  = 1'($urandom);
            bank_sel  = 1'($urandom);
            wr_n      = 1'($urandom);
        end
        host_ce_n = 1'b0; ext_ce_n = 1'b1; bank_sel = 1'b1; wr_n = 1'b0;
        step();
        chk(!ram_ce1_n && ram_ce0_n, "R2", "bank1 select", {ram_ce1_n, ram_ce0_n}, 1);
        ext_ce_n = 1'b0;
        step();
        chk(reg_we && ram_ce1_n, "R5", "reg write allowed", reg_we, 1);

        // R6 with register write and bank 1: drop power, write blocked while cs stays
        cur_req = "R6";
        pwr_good = 1'b0;
        repeat (2) step();
        chk(!reg_we && reg_cs, "R6", "reg write blocked", reg_we, 0);
        ext_ce_n = 1'b1; bank_sel = 1'b0;

        // R8: glitch during recovery restarts the full interval
        cur_req = "R8";
        repeat (3) step();
        pwr_good = 1'b1;
        repeat (5) step();
        pwr_good = 1'b0;
        step();
        pwr_good = 1'b1;
        wait_ce0(1'b0, k);
        chk(k == RC + 3, "R8", "latency after abort", k, RC + 3);

        // R10: single-sample glitch in POWER_OK
        cur_req = "R10";
        repeat (5) step();
        pwr_good = 1'b0;
        step();
        pwr_good = 1'b1;
        step();
        chk(ram_ce0_n, "R10", "ce off after glitch", ram_ce0_n, 1);
        wait_ce0(1'b0, k);
        chk(k == RC + 2, "R10", "relatch after glitch", k, RC + 2);

        // R1: reset again mid-access
        cur_req = "R1";
        rst_n = 1'b0;
        step();
        chk(ram_ce0_n && !reg_we, "R1", "ce at reset", ram_ce0_n, 1);
        rst_n = 1'b1;
        repeat (3) step();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule